// File: doc/BRIEF.md
# Subpage-Masked Translation Buffer

This block is a small fully associative address translation buffer in which each entry maps one 64KB physical page, while access rights cover only an aligned power-of-two group of 4KB subpages inside that page. The tag is held at 4KB resolution. A four-bit mask is derived from a subpage-count code when the entry is written, and that mask selects how many of the low tag bits take part in the compare. One entry can therefore answer for 1, 2, 4, 8 or all 16 subpages of its page. Subpages outside the group do not match, so that entry gives no access to them.

Software or a walker writes entries through a load port: an entry index, a virtual page tag, a physical frame number, a size code and read/write/execute permissions. The lookup port is combinational. It takes a virtual address and an access type and returns hit, the winning entry index, a permission fault flag and the physical address. The low 16 address bits pass through untranslated. A flush input invalidates every entry in one cycle.

Top module: `tlb_subpage_top`

## Requirements
- R1: After reset no entry is valid: every lookup gives hit_o=0, fault_o=0 and pa_o=0.
- R2: When ld_en_i is high at a rising clock edge, the entry at ld_idx_i is written and marked valid. The new entry is visible to lookups from the next cycle on. A lookup in the same cycle as the load still sees the previous contents.
- R3: The size code ld_size_i sets the mask: 0 gives 1 subpage (mask 1111), 1 gives 2 (1110), 2 gives 4 (1100), 3 gives 8 (1000), and 4 to 7 give all 16 (0000).
- R4: An entry matches when it is valid, lk_va_i[63:16] equals the stored tag bits [51:4], and lk_va_i[15:12] ANDed with the mask equals the stored low tag bits. Subpages outside the group miss.
- R5: On load, the low four tag bits are stored already ANDed with the mask, so an unaligned ld_vpn_i[3:0] is forced down to the group's aligned base.
- R6: On a hit without fault, pa_o = {frame number, lk_va_i[15:0]}. Otherwise pa_o = 0.
- R7: ld_perm_i bit 0 grants read, bit 1 write and bit 2 execute. lk_acc_i is 0 for read, 1 for write and 2 for execute; 3 is reserved and never permitted. When the access is not permitted on a hit, the outputs are fault_o=1, hit_o=1 and pa_o=0.
- R8: If several entries match, the lowest index wins, and hit_idx_o reports that index (0 on a miss).
- R9: flush_i clears all valid bits at one edge. A load in the same cycle as a flush is discarded.
- R10: Entries that map different virtual tags to the same frame with disjoint subpage groups each translate their own subpages to that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Invalidate all entries |
| ld_en_i | input | 1 | Write the entry selected by ld_idx_i |
| ld_idx_i | input | 4 | Entry index to write |
| ld_vpn_i | input | 52 | Virtual tag, VA[63:12] |
| ld_pfn_i | input | 48 | Physical frame, PA[63:16] |
| ld_size_i | input | 3 | Subpage-count code |
| ld_perm_i | input | 3 | Permissions {x,w,r} |
| lk_va_i | input | 64 | Lookup virtual address |
| lk_acc_i | input | 2 | Access type |
| hit_o | output | 1 | An entry matched |
| hit_idx_o | output | 4 | Winning entry index |
| fault_o | output | 1 | Hit with the access not permitted |
| pa_o | output | 64 | Translated physical address |

## Verification
Two pairs of functions can fall in the same cycle. A load can meet a flush, and a load can meet a lookup of the address being loaded. The bench drives flush and load in one cycle, then looks up the loaded address and expects a miss, because the flush wins. It also presents a lookup of an entry while that entry is being written, and expects a miss in that cycle and a hit in the next. Random loads draw from a small pool of upper tags, so overlapping matches of different sizes occur, and each lookup is compared with a bench model of the priority and mask rules.

// File: rtl/tlb_sp_pkg.sv
package tlb_sp_pkg;
  parameter int unsigned VA_W  = 64;
  parameter int unsigned PG_W  = 16;   // 64KB page
  parameter int unsigned SUB_W = 12;   // 4KB subpage
  parameter int unsigned SP_W  = PG_W - SUB_W;
  parameter int unsigned VPN_W = VA_W - SUB_W;
  parameter int unsigned PFN_W = VA_W - PG_W;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;
endpackage

// File: rtl/tlb_sp_mask_gen.sv
module tlb_sp_mask_gen
  import tlb_sp_pkg::*;
(
  input  logic [2:0]      size_i,
  output logic [SP_W-1:0] mask_o
);
  always_comb begin
    unique case (size_i)
      3'd0:    mask_o = 4'b1111;
      3'd1:    mask_o = 4'b1110;
      3'd2:    mask_o = 4'b1100;
      3'd3:    mask_o = 4'b1000;
      default: mask_o = 4'b0000;
    endcase
  end
endmodule

// File: rtl/tlb_sp_entry.sv
module tlb_sp_entry
  import tlb_sp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             we_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PFN_W-1:0] pfn_i,
  input  logic [SP_W-1:0]  mask_i,
  input  logic [2:0]       perm_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  output logic             match_o,
  output logic [PFN_W-1:0] pfn_o,
  output logic [2:0]       perm_o
);
  localparam int unsigned HI_W = VPN_W - SP_W;

  logic            valid_q;
  logic [HI_W-1:0] tag_hi_q;
  logic [SP_W-1:0] tag_lo_q;
  logic [SP_W-1:0] mask_q;
  logic [PFN_W-1:0] pfn_q;
  logic [2:0]      perm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q  <= 1'b0;
      tag_hi_q <= '0;
      tag_lo_q <= '0;
      mask_q   <= '0;
      pfn_q    <= '0;
      perm_q   <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end else if (we_i) begin
      valid_q  <= 1'b1;
      tag_hi_q <= vpn_i[VPN_W-1:SP_W];
      tag_lo_q <= vpn_i[SP_W-1:0] & mask_i;  // force group alignment
      mask_q   <= mask_i;
      pfn_q    <= pfn_i;
      perm_q   <= perm_i;
    end
  end

  assign match_o = valid_q
                 && (lk_vpn_i[VPN_W-1:SP_W] == tag_hi_q)
                 && ((lk_vpn_i[SP_W-1:0] & mask_q) == tag_lo_q);
  assign pfn_o   = pfn_q;
  assign perm_o  = perm_q;
endmodule

// File: rtl/tlb_sp_prio_sel.sv
module tlb_sp_prio_sel #(
  parameter int unsigned N     = 16,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_subpage_top.sv
module tlb_subpage_top
  import tlb_sp_pkg::*;
#(
  parameter int unsigned NUM_ENT = 16,
  localparam int unsigned IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             ld_en_i,
  input  logic [IDX_W-1:0] ld_idx_i,
  input  logic [VPN_W-1:0] ld_vpn_i,
  input  logic [PFN_W-1:0] ld_pfn_i,
  input  logic [2:0]       ld_size_i,
  input  logic [2:0]       ld_perm_i,
  input  logic [VA_W-1:0]  lk_va_i,
  input  logic [1:0]       lk_acc_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o,
  output logic             fault_o,
  output logic [VA_W-1:0]  pa_o
);
  logic [SP_W-1:0]    ld_mask;
  logic [NUM_ENT-1:0] match;
  logic [PFN_W-1:0]   ent_pfn  [NUM_ENT];
  logic [2:0]         ent_perm [NUM_ENT];
  logic               any_hit;
  logic [IDX_W-1:0]   sel_idx;
  logic [2:0]         sel_perm;
  logic               allowed;

  tlb_sp_mask_gen i_mask_gen (
    .size_i (ld_size_i),
    .mask_o (ld_mask)
  );

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    tlb_sp_entry i_entry (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .flush_i  (flush_i),
      .we_i     (ld_en_i && (ld_idx_i == IDX_W'(g))),
      .vpn_i    (ld_vpn_i),
      .pfn_i    (ld_pfn_i),
      .mask_i   (ld_mask),
      .perm_i   (ld_perm_i),
      .lk_vpn_i (lk_va_i[VA_W-1:SUB_W]),
      .match_o  (match[g]),
      .pfn_o    (ent_pfn[g]),
      .perm_o   (ent_perm[g])
    );
  end

  tlb_sp_prio_sel #(.N(NUM_ENT)) i_prio (
    .req_i (match),
    .any_o (any_hit),
    .idx_o (sel_idx)
  );

  assign sel_perm = ent_perm[sel_idx];

  always_comb begin
    unique case (acc_e'(lk_acc_i))
      ACC_RD:  allowed = sel_perm[0];
      ACC_WR:  allowed = sel_perm[1];
      ACC_EX:  allowed = sel_perm[2];
      default: allowed = 1'b0;
    endcase
  end

  assign hit_o     = any_hit;
  assign hit_idx_o = sel_idx;
  assign fault_o   = any_hit && !allowed;
  assign pa_o      = (any_hit && allowed) ? {ent_pfn[sel_idx], lk_va_i[PG_W-1:0]} : '0;
endmodule

// File: rtl/tlb_subpage_chk.sv
module tlb_subpage_chk #(
  parameter int unsigned IDX_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic [63:0]      lk_va_i,
  input logic             hit_o,
  input logic [IDX_W-1:0] hit_idx_o,
  input logic             fault_o,
  input logic [63:0]      pa_o
);
  // R7
  fault_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> hit_o);

  // R6
  pa_offset_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !fault_o) |-> (pa_o[15:0] == lk_va_i[15:0]));

  // R6
  pa_zero_on_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (pa_o == 64'd0));

  // R1
  miss_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (pa_o == 64'd0 && !fault_o));

  // R8
  miss_idx_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (hit_idx_o == '0));

  // R9
  flush_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !hit_o);
endmodule

bind tlb_subpage_top tlb_subpage_chk #(.IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_tlb_subpage_top.sv
module test_tlb_subpage_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [51:0] ld_vpn = '0;
  logic [47:0] ld_pfn = '0;
  logic [2:0]  ld_size = '0;
  logic [2:0]  ld_perm = '0;
  logic [63:0] lk_va = '0;
  logic [1:0]  lk_acc = '0;
  logic        hit, fault;
  logic [3:0]  hit_idx;
  logic [63:0] pa;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  bit          m_valid [16];
  logic [51:0] m_vpn   [16];
  logic [47:0] m_pfn   [16];
  logic [2:0]  m_size  [16];
  logic [2:0]  m_perm  [16];
  logic [47:0] pool    [4];

  always #2 clk = ~clk;

  tlb_subpage_top i_tlb_subpage_top (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .ld_en_i(ld_en), .ld_idx_i(ld_idx),
    .ld_vpn_i(ld_vpn), .ld_pfn_i(ld_pfn), .ld_size_i(ld_size), .ld_perm_i(ld_perm),
    .lk_va_i(lk_va), .lk_acc_i(lk_acc), .hit_o(hit), .hit_idx_o(hit_idx),
    .fault_o(fault), .pa_o(pa)
  );

  function automatic logic [3:0] grp_mask(logic [2:0] sz);
    return (sz >= 3'd4) ? 4'h0 : 4'((4'hF << sz) & 4'hF);
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Expected {hit, idx, fault, pa} from the model
  task automatic check_look(string req);
    bit e_hit = 0, e_fault = 0, ok;
    logic [3:0]  e_idx = 0;
    logic [63:0] e_pa = 0;
    for (int i = 0; i < 16; i++) begin
      logic [3:0] mk = grp_mask(m_size[i]);
      if (!e_hit && m_valid[i] && m_vpn[i][51:4] == lk_va[63:16]
          && (lk_va[15:12] & mk) == (m_vpn[i][3:0] & mk)) begin
        e_hit = 1;
        e_idx = 4'(i);
      end
    end
    if (e_hit) begin
      ok = (lk_acc == 2'd0) ? m_perm[e_idx][0] :
           (lk_acc == 2'd1) ? m_perm[e_idx][1] :
           (lk_acc == 2'd2) ? m_perm[e_idx][2] : 1'b0;
      e_fault = !ok;
      e_pa = ok ? {m_pfn[e_idx], lk_va[15:0]} : 64'd0;
    end
    chk({req, " hit"}, 64'(hit), 64'(e_hit));
    chk({req, " idx"}, 64'(hit_idx), 64'(e_idx));
    chk({req, " fault"}, 64'(fault), 64'(e_fault));
    chk({req, " pa"}, pa, e_pa);
  endtask

  task automatic do_load(logic [3:0] idx, logic [51:0] vpn, logic [47:0] pfn,
                         logic [2:0] sz, logic [2:0] pm);
    @(negedge clk);
    ld_idx = idx; ld_vpn = vpn; ld_pfn = pfn; ld_size = sz; ld_perm = pm; ld_en = 1;
    @(posedge clk);
    #1 ld_en = 0;
    m_valid[idx] = 1; m_vpn[idx] = vpn; m_pfn[idx] = pfn; m_size[idx] = sz; m_perm[idx] = pm;
  endtask

  task automatic look(logic [63:0] va, logic [1:0] acc, string req);
    @(negedge clk);
    lk_va = va; lk_acc = acc;
    #1 check_look(req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    for (int i = 0; i < 16; i++) begin
      m_valid[i] = 0; m_vpn[i] = 0; m_pfn[i] = 0; m_size[i] = 0; m_perm[i] = 0;
    end
    for (int k = 0; k < 4; k++) pool[k] = {$urandom, $urandom};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    look({pool[0], 16'h3456}, 2'd0, "R1 reset");
    chk("R1 reset hit", 64'(hit), 64'd0);

    // R3/R4 single subpage: only subpage 5 matches
    do_load(4'd2, {48'hA000_0000_0001, 4'h5}, 48'h0000_0000_0BEE, 3'd0, 3'b111);
    look(64'hA000_0000_0001_5ABC, 2'd0, "R4 exact subpage");
    chk("R6 pa", pa, 64'h0000_0000_0BEE_5ABC);
    look(64'hA000_0000_0001_4ABC, 2'd0, "R4 neighbour subpage");
    chk("R4 neighbour miss", 64'(hit), 64'd0);

    // R5 unaligned tag, size 4 subpages: group 4..7
    do_load(4'd3, {48'hA000_0000_0002, 4'h6}, 48'h0000_0000_0C00, 3'd2, 3'b001);
    look(64'hA000_0000_0002_4010, 2'd0, "R5 aligned base");
    chk("R5 base hit", 64'(hit), 64'd1);
    look(64'hA000_0000_0002_7010, 2'd0, "R5 group top");
    look(64'hA000_0000_0002_8010, 2'd0, "R3 outside group");
    chk("R3 outside miss", 64'(hit), 64'd0);

    // R7 permission faults
    look(64'hA000_0000_0002_5000, 2'd1, "R7 write denied");
    chk("R7 fault", 64'(fault), 64'd1);
    look(64'hA000_0000_0002_5000, 2'd3, "R7 reserved access");
    look(64'hA000_0000_0001_5000, 2'd2, "R7 exec granted");

    // R3 code 6 maps whole page; R8 overlap with entry 2 (lower wins)
    do_load(4'd9, {48'hA000_0000_0001, 4'h9}, 48'h0000_0000_0DDD, 3'd6, 3'b011);
    look(64'hA000_0000_0001_5000, 2'd0, "R8 low index wins");
    chk("R8 idx", 64'(hit_idx), 64'd2);
    look(64'hA000_0000_0001_F000, 2'd1, "R3 whole page");
    chk("R3 whole idx", 64'(hit_idx), 64'd9);

    // R10 same frame, disjoint groups, different tags
    do_load(4'd10, {48'hB000_0000_0010, 4'h0}, 48'h0000_0000_0777, 3'd3, 3'b001);
    do_load(4'd11, {48'hC000_0000_0020, 4'h8}, 48'h0000_0000_0777, 3'd3, 3'b001);
    look(64'hB000_0000_0010_3004, 2'd0, "R10 lower half");
    chk("R10 pa lo", pa, 64'h0000_0000_0777_3004);
    look(64'hC000_0000_0020_C004, 2'd0, "R10 upper half");
    chk("R10 pa hi", pa, 64'h0000_0000_0777_C004);
    look(64'hC000_0000_0020_3004, 2'd0, "R10 other half");
    chk("R10 miss", 64'(hit), 64'd0);

    // R9 flush and load in the same cycle: flush wins
    @(negedge clk);
    flush = 1; ld_en = 1; ld_idx = 4'd5; ld_vpn = {48'hD000_0000_0005, 4'h0};
    ld_pfn = 48'h1; ld_size = 3'd4; ld_perm = 3'b111;
    @(posedge clk);
    #1 flush = 0; ld_en = 0;
    for (int i = 0; i < 16; i++) m_valid[i] = 0;
    look(64'hD000_0000_0005_0000, 2'd0, "R9 flush beats load");
    chk("R9 miss", 64'(hit), 64'd0);
    look(64'hA000_0000_0001_5ABC, 2'd0, "R9 old entry gone");

    // R2 load and lookup of same address in one cycle
    @(negedge clk);
    ld_idx = 4'd7; ld_vpn = {48'hE000_0000_0007, 4'h1}; ld_pfn = 48'h42;
    ld_size = 3'd0; ld_perm = 3'b001; ld_en = 1;
    lk_va = 64'hE000_0000_0007_1000; lk_acc = 2'd0;
    #1 chk("R2 same-cycle miss", 64'(hit), 64'd0);
    @(posedge clk);
    #1 ld_en = 0;
    m_valid[7] = 1; m_vpn[7] = ld_vpn; m_pfn[7] = 48'h42; m_size[7] = 3'd0; m_perm[7] = 3'b001;
    @(negedge clk);
    #1 chk("R2 next-cycle hit", 64'(hit), 64'd1);
    check_look("R2 after load");

    // Random mix against model
    for (int n = 0; n < 600; n++) begin
      int unsigned r = $urandom % 10;
      if (r < 3) begin
        do_load(4'($urandom), {pool[$urandom % 4], 4'($urandom)}, 48'({$urandom, $urandom}),
                3'($urandom), 3'($urandom));
      end else if (r == 3 && ($urandom % 8) == 0) begin
        @(negedge clk);
        flush = 1;
        @(posedge clk);
        #1 flush = 0;
        for (int i = 0; i < 16; i++) m_valid[i] = 0;
      end else begin
        look({pool[$urandom % 4], 16'($urandom)}, 2'($urandom), "R4 R7 R8 random");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule